// File: doc/BRIEF.md
# Merging Cache Miss Handler

This block tracks outstanding line misses for a non-blocking data cache. Each of its entries owns a full cache-line buffer. A load or store that missed in the cache is presented as a lookup. If an entry already holds that line, the request joins it. Otherwise it takes the lowest-numbered free entry. If neither is possible, it is turned away, and the pipeline puts the load or store to sleep until a not-full event.

Store bytes go into the entry's buffer at once, and a per-byte mask records which bytes they touched. The block asks the bus side for each new line, oldest entry first. Returning beats fill only the bytes that no store has written. When every beat of a line is in, the entry asks the load/store pipeline for a cache fill, unless the victim buffer is full. When the pipeline takes the fill, the entry frees. On the next cycle the block broadcasts the entry number to wake waiting loads and pulses a not-full event.

Top module: `miss_merge_queue`

## Requirements
- R1: A lookup presented in a cycle (`lk_valid`=1) produces exactly one registered response on the following cycle (`rsp_valid`=1). `rsp_valid` is 0 in cycles that follow no lookup.
- R2: A lookup whose line address equals that of a held entry merges into it (`rsp_merged`=1, `rsp_idx` = that entry). Any other accepted lookup takes the lowest-numbered free entry (`rsp_merged`=0).
- R3: `full` is 1 exactly when every entry is held. A lookup that finds no matching entry and no free entry is rejected (`rsp_ok`=0, `rsp_idx` meaningless) and changes no state.
- R4: An entry whose fill the pipeline accepts in a cycle counts as free for a lookup in that same cycle and is never merged into. A lookup to its line in that cycle allocates a fresh entry, which may be the one being released.
- R5: An accepted store writes the bytes selected by `lk_be` into the target entry's buffer, for both new and merged entries. Byte b of the line is `lk_data[8b+7:8b]`. The store sets the matching mask bits, and a later store to the same byte overwrites it.
- R6: Bus beats for an entry arrive in order. Beat k carries bytes k*BEAT_BYTES up to (k+1)*BEAT_BYTES-1, with byte lane j at `bdat_data[8j+7:8j]`. A beat writes only bytes whose store mask bit is clear.
- R7: If a store and a bus beat write the same byte of the same entry in the same cycle, the store's value is kept.
- R8: Each newly allocated entry is offered on the request port exactly once, in allocation order. The offer holds (`breq_valid`, `breq_idx`, `breq_line`) until `breq_ready` is 1.
- R9: Once all beats of an entry have arrived, `fill_valid` is 1 with the lowest-numbered complete entry's index, line address and merged data, but never while `vq_full` is 1.
- R10: When the pipeline accepts a fill (`fill_valid` and `fill_ready` both 1), the entry frees. On the next cycle `wake_valid`=1 with `wake_idx` = that entry, and `notfull_evt`=1. Neither is raised in any other cycle.
- R11: After reset no entry is held: `full`, `breq_valid`, `fill_valid`, `rsp_valid`, `wake_valid` and `notfull_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Miss lookup present this cycle |
| lk_store | input | 1 | Lookup comes from a store |
| lk_line | input | LA_W | Line address of the miss |
| lk_be | input | LINE_BYTES | Store byte enables within the line |
| lk_data | input | LINE_BYTES*8 | Store data, line aligned |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ok | output | 1 | Lookup was accepted |
| rsp_idx | output | IDX_W | Entry assigned to the lookup |
| rsp_merged | output | 1 | Lookup joined an existing entry |
| full | output | 1 | No entry is free |
| notfull_evt | output | 1 | Pulse: an entry was released |
| breq_valid | output | 1 | Line request offered to the bus side |
| breq_ready | input | 1 | Bus side takes the request |
| breq_idx | output | IDX_W | Entry of the requested line |
| breq_line | output | LA_W | Line address requested |
| bdat_valid | input | 1 | Returning beat present |
| bdat_idx | input | IDX_W | Entry the beat belongs to |
| bdat_data | input | BEAT_BYTES*8 | Beat payload |
| vq_full | input | 1 | Victim buffer full; holds fills back |
| fill_valid | output | 1 | Fill request to the pipeline |
| fill_ready | input | 1 | Pipeline accepts the fill |
| fill_idx | output | IDX_W | Entry being filled |
| fill_line | output | LA_W | Line address of the fill |
| fill_data | output | LINE_BYTES*8 | Merged line data |
| wake_valid | output | 1 | Broadcast of a completed entry |
| wake_idx | output | IDX_W | Entry number broadcast |

## Verification
The properties assume a well-behaved bus side. Beats arrive only for an entry whose request was taken and that still lacks beats, and never more than BEATS of them. Lookups need no such limits. The stimulus respects the bus rule by choosing beat targets from the bench's own record of which entries have been requested and how many beats each has received. Lookups, ready signals and victim-buffer pressure are otherwise left free to collide with fills and beats. Line addresses are drawn from a small set, so merges, full rejections and allocate-on-release cases all occur often.

// File: rtl/mmq_pkg.sv
package mmq_pkg;
  localparam int unsigned MAX_SLOTS = 64;
  localparam int unsigned MAX_IDX_W = $clog2(MAX_SLOTS);
  typedef logic [MAX_SLOTS-1:0] slot_vec_t;

  // Lowest set bit position; zero when the vector is empty.
  function automatic logic [MAX_IDX_W-1:0] first_one(input slot_vec_t v);
    logic [MAX_IDX_W-1:0] r;
    r = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = MAX_IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/mmq_lookup.sv
module mmq_lookup
  import mmq_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LA_W = 28,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] busy,
  input  logic [ENTRIES-1:0] leaving,
  input  logic [LA_W-1:0]    line_tab [ENTRIES],
  input  logic [LA_W-1:0]    key,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               any_free,
  output logic [IDX_W-1:0]   free_idx
);
  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] match;

  assign live = busy & ~leaving;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = live[i] && (line_tab[i] == key);
    end
  end

  assign hit      = |match;
  assign hit_idx  = IDX_W'(first_one(slot_vec_t'(match)));
  assign any_free = |(~live);
  assign free_idx = IDX_W'(first_one(slot_vec_t'(~live)));
endmodule

// File: rtl/mmq_order.sv
module mmq_order #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_idx
);
  logic [IDX_W-1:0] ring [ENTRIES];
  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop;

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  assign head_valid = (count != '0);
  assign head_idx   = ring[rd_ptr];
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= step_ptr(wr_ptr);
      if (do_pop) rd_ptr <= step_ptr(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/mmq_slot.sv
module mmq_slot #(
  parameter int LA_W = 28,
  parameter int LINE_BYTES = 16,
  parameter int BEAT_BYTES = 4,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int BEAT_W = BEAT_BYTES * 8,
  localparam int BEATS = LINE_BYTES / BEAT_BYTES,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc,
  input  logic [LA_W-1:0]       set_line,
  input  logic                  st_we,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic [LINE_W-1:0]     st_data,
  input  logic                  beat_we,
  input  logic [BEAT_W-1:0]     beat_data,
  input  logic                  release_i,
  output logic                  busy,
  output logic                  complete,
  output logic [LA_W-1:0]       line_o,
  output logic [LINE_W-1:0]     data_o
);
  logic [CNT_W-1:0]      cnt_q;
  logic [LINE_BYTES-1:0] mask_q;
  logic [LINE_W-1:0]     buf_q;
  logic [LA_W-1:0]       line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (alloc) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else begin
        if (release_i) busy <= 1'b0;
        if (beat_we)   cnt_q <= cnt_q + CNT_W'(1);
      end
      if (alloc)      mask_q <= st_we ? st_be : '0;
      else if (st_we) mask_q <= mask_q | st_be;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) line_q <= set_line;
  end

  // Store bytes take precedence over a beat landing in the same cycle.
  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (st_we && st_be[b])
        buf_q[b*8 +: 8] <= st_data[b*8 +: 8];
      else if (beat_we && !mask_q[b] && (cnt_q == CNT_W'(b / BEAT_BYTES)))
        buf_q[b*8 +: 8] <= beat_data[(b % BEAT_BYTES)*8 +: 8];
    end
  end

  assign complete = busy && (cnt_q == CNT_W'(BEATS));
  assign line_o   = line_q;
  assign data_o   = buf_q;
endmodule

// File: rtl/miss_merge_queue.sv
module miss_merge_queue
  import mmq_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LA_W = 28,
  parameter int LINE_BYTES = 16,
  parameter int BEAT_BYTES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int BEAT_W = BEAT_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_valid,
  input  logic                  lk_store,
  input  logic [LA_W-1:0]       lk_line,
  input  logic [LINE_BYTES-1:0] lk_be,
  input  logic [LINE_W-1:0]     lk_data,
  output logic                  rsp_valid,
  output logic                  rsp_ok,
  output logic [IDX_W-1:0]      rsp_idx,
  output logic                  rsp_merged,
  output logic                  full,
  output logic                  notfull_evt,
  output logic                  breq_valid,
  input  logic                  breq_ready,
  output logic [IDX_W-1:0]      breq_idx,
  output logic [LA_W-1:0]       breq_line,
  input  logic                  bdat_valid,
  input  logic [IDX_W-1:0]      bdat_idx,
  input  logic [BEAT_W-1:0]     bdat_data,
  input  logic                  vq_full,
  output logic                  fill_valid,
  input  logic                  fill_ready,
  output logic [IDX_W-1:0]      fill_idx,
  output logic [LA_W-1:0]       fill_line,
  output logic [LINE_W-1:0]     fill_data,
  output logic                  wake_valid,
  output logic [IDX_W-1:0]      wake_idx
);
  logic [ENTRIES-1:0] slot_busy;
  logic [ENTRIES-1:0] slot_done;
  logic [LA_W-1:0]    slot_line [ENTRIES];
  logic [LINE_W-1:0]  slot_data [ENTRIES];

  logic [IDX_W-1:0]   fill_pick;
  logic               fill_take;
  logic [ENTRIES-1:0] leave_vec;

  logic               hit, any_free, acc_ok, do_alloc, do_store;
  logic [IDX_W-1:0]   hit_idx, free_idx, tgt_idx;

  // Fill selection: lowest complete entry, held back by victim pressure.
  assign fill_pick  = IDX_W'(first_one(slot_vec_t'(slot_done)));
  assign fill_valid = (|slot_done) && !vq_full;
  assign fill_idx   = fill_pick;
  assign fill_line  = slot_line[fill_pick];
  assign fill_data  = slot_data[fill_pick];
  assign fill_take  = fill_valid && fill_ready;
  assign leave_vec  = fill_take ? (ENTRIES'(1) << fill_pick) : '0;

  mmq_lookup #(.ENTRIES(ENTRIES), .LA_W(LA_W)) u_lookup (
    .busy     (slot_busy),
    .leaving  (leave_vec),
    .line_tab (slot_line),
    .key      (lk_line),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  assign acc_ok   = hit || any_free;
  assign tgt_idx  = hit ? hit_idx : free_idx;
  assign do_alloc = lk_valid && !hit && any_free;
  assign do_store = lk_valid && lk_store && acc_ok;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    mmq_slot #(.LA_W(LA_W), .LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .alloc     (do_alloc && (tgt_idx == IDX_W'(i))),
      .set_line  (lk_line),
      .st_we     (do_store && (tgt_idx == IDX_W'(i))),
      .st_be     (lk_be),
      .st_data   (lk_data),
      .beat_we   (bdat_valid && (bdat_idx == IDX_W'(i))),
      .beat_data (bdat_data),
      .release_i (leave_vec[i]),
      .busy      (slot_busy[i]),
      .complete  (slot_done[i]),
      .line_o    (slot_line[i]),
      .data_o    (slot_data[i])
    );
  end

  mmq_order #(.ENTRIES(ENTRIES)) u_order (
    .clk        (clk),
    .rst        (rst),
    .push       (do_alloc),
    .push_idx   (tgt_idx),
    .pop        (breq_ready),
    .head_valid (breq_valid),
    .head_idx   (breq_idx)
  );

  assign breq_line = slot_line[breq_idx];
  assign full      = &slot_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_idx     <= '0;
      rsp_merged  <= 1'b0;
      wake_valid  <= 1'b0;
      wake_idx    <= '0;
      notfull_evt <= 1'b0;
    end else begin
      rsp_valid   <= lk_valid;
      rsp_ok      <= lk_valid && acc_ok;
      rsp_idx     <= tgt_idx;
      rsp_merged  <= lk_valid && hit;
      wake_valid  <= fill_take;
      wake_idx    <= fill_pick;
      notfull_evt <= fill_take;
    end
  end
endmodule

// File: rtl/mmq_checker.sv
module mmq_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             full,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             vq_full,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [IDX_W-1:0] fill_idx,
  input logic             wake_valid,
  input logic [IDX_W-1:0] wake_idx,
  input logic             notfull_evt,
  input logic             breq_valid,
  input logic             breq_ready,
  input logic [IDX_W-1:0] breq_idx
);
  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid));

  // R3
  reject_only_full_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> $past(full));

  // R9
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !vq_full);

  // R10
  wake_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_ready) |=> (wake_valid && wake_idx == $past(fill_idx)));

  // R10
  notfull_origin_chk: assert property (@(posedge clk) disable iff (rst)
    notfull_evt |-> $past(fill_valid && fill_ready));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (breq_valid && !breq_ready) |=> (breq_valid && $stable(breq_idx)));
endmodule

bind miss_merge_queue mmq_checker #(.IDX_W(IDX_W)) u_mmq_checker (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .full        (full),
  .rsp_valid   (rsp_valid),
  .rsp_ok      (rsp_ok),
  .vq_full     (vq_full),
  .fill_valid  (fill_valid),
  .fill_ready  (fill_ready),
  .fill_idx    (fill_idx),
  .wake_valid  (wake_valid),
  .wake_idx    (wake_idx),
  .notfull_evt (notfull_evt),
  .breq_valid  (breq_valid),
  .breq_ready  (breq_ready),
  .breq_idx    (breq_idx)
);

// File: tb/sim_miss_merge_queue.sv
module sim_miss_merge_queue;
  localparam int CLK_P = 10;
  localparam int NE = 4;
  localparam int LAW = 28;
  localparam int LB = 16;
  localparam int BB = 4;
  localparam int NBEAT = LB / BB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic            lk_valid = 0, lk_store = 0;
  logic [LAW-1:0]  lk_line = '0;
  logic [LB-1:0]   lk_be = '0;
  logic [LB*8-1:0] lk_data = '0;
  logic            breq_ready = 0, bdat_valid = 0, vq_full = 0, fill_ready = 0;
  logic [1:0]      bdat_idx = '0;
  logic [BB*8-1:0] bdat_data = '0;

  logic            rsp_valid, rsp_ok, rsp_merged, full, notfull_evt;
  logic [1:0]      rsp_idx, breq_idx, fill_idx, wake_idx;
  logic            breq_valid, fill_valid, wake_valid;
  logic [LAW-1:0]  breq_line, fill_line;
  logic [LB*8-1:0] fill_data;

  miss_merge_queue #(.ENTRIES(NE), .LA_W(LAW), .LINE_BYTES(LB), .BEAT_BYTES(BB)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_store(lk_store), .lk_line(lk_line),
    .lk_be(lk_be), .lk_data(lk_data), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_idx(rsp_idx), .rsp_merged(rsp_merged), .full(full), .notfull_evt(notfull_evt),
    .breq_valid(breq_valid), .breq_ready(breq_ready), .breq_idx(breq_idx),
    .breq_line(breq_line), .bdat_valid(bdat_valid), .bdat_idx(bdat_idx),
    .bdat_data(bdat_data), .vq_full(vq_full), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_idx(fill_idx), .fill_line(fill_line),
    .fill_data(fill_data), .wake_valid(wake_valid), .wake_idx(wake_idx)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference state
  bit         mv [NE];
  bit         mreq [NE];
  int         mcnt [NE];
  logic [LAW-1:0] mline [NE];
  bit         mmask [NE][LB];
  logic [7:0] mdat [NE][LB];
  int         oq [$];
  bit         m_rsp_v, m_rsp_ok, m_rsp_mg, m_wake_v, m_nf;
  int         m_rsp_idx, m_wake_idx;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ready_pick();
    for (int i = 0; i < NE; i++) if (mv[i] && mcnt[i] == NBEAT) return i;
    return -1;
  endfunction

  task automatic compare_all();
    int fi;
    bit allb;
    logic [127:0] ev;
    fi = ready_pick();
    allb = 1;
    for (int i = 0; i < NE; i++) if (!mv[i]) allb = 0;
    chk("R1 rsp_valid", rsp_valid, m_rsp_v);
    if (m_rsp_v) begin
      chk("R3 rsp_ok", rsp_ok, m_rsp_ok);
      if (m_rsp_ok) begin
        chk("R2 rsp_idx", rsp_idx, m_rsp_idx);
        chk("R2 rsp_merged", rsp_merged, m_rsp_mg);
      end
    end
    chk("R3 full", full, allb);
    chk("R8 breq_valid", breq_valid, oq.size() > 0);
    if (oq.size() > 0) begin
      chk("R8 breq_idx", breq_idx, oq[0]);
      chk("R8 breq_line", breq_line, mline[oq[0]]);
    end
    chk("R9 fill_valid", fill_valid, (fi >= 0) && !vq_full);
    if ((fi >= 0) && !vq_full) begin
      chk("R9 fill_idx", fill_idx, fi);
      chk("R9 fill_line", fill_line, mline[fi]);
      ev = '0;
      for (int b = 0; b < LB; b++) ev[b*8 +: 8] = mdat[fi][b];
      chk("R5 R6 R7 fill_data", fill_data, ev);
    end
    chk("R10 wake_valid", wake_valid, m_wake_v);
    if (m_wake_v) chk("R10 wake_idx", wake_idx, m_wake_idx);
    chk("R10 notfull_evt", notfull_evt, m_nf);
  endtask

  task automatic model_step();
    int fi, hit, fr, tgt, e;
    bit acc, ok;
    fi = ready_pick();
    acc = (fi >= 0) && !vq_full && fill_ready;
    hit = -1; fr = -1; ok = 0; tgt = 0;
    if (lk_valid) begin
      for (int i = 0; i < NE; i++)
        if (hit < 0 && mv[i] && !(acc && i == fi) && mline[i] == lk_line) hit = i;
      for (int i = 0; i < NE; i++)
        if (fr < 0 && (!mv[i] || (acc && i == fi))) fr = i;
      ok = (hit >= 0) || (fr >= 0);
      tgt = (hit >= 0) ? hit : fr;
    end
    if (bdat_valid) begin
      e = bdat_idx;
      for (int j = 0; j < BB; j++) begin
        int b;
        b = mcnt[e] * BB + j;
        if (!mmask[e][b] && !(lk_valid && lk_store && ok && tgt == e && lk_be[b]))
          mdat[e][b] = bdat_data[j*8 +: 8];
      end
      mcnt[e]++;
    end
    if (oq.size() > 0 && breq_ready) begin
      mreq[oq[0]] = 1;
      void'(oq.pop_front());
    end
    if (acc) mv[fi] = 0;
    if (lk_valid && ok && hit < 0) begin
      mv[tgt] = 1; mline[tgt] = lk_line; mcnt[tgt] = 0; mreq[tgt] = 0;
      for (int b = 0; b < LB; b++) mmask[tgt][b] = 0;
      oq.push_back(tgt);
    end
    if (lk_valid && ok && lk_store)
      for (int b = 0; b < LB; b++)
        if (lk_be[b]) begin
          mmask[tgt][b] = 1;
          mdat[tgt][b] = lk_data[b*8 +: 8];
        end
    m_rsp_v = lk_valid; m_rsp_ok = lk_valid && ok; m_rsp_idx = tgt; m_rsp_mg = (hit >= 0);
    m_wake_v = acc; m_wake_idx = fi; m_nf = acc;
  endtask

  task automatic cycle_begin();
    @(negedge clk);
    compare_all();
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_store = 0; lk_be = '0; lk_data = '0;
    breq_ready = 0; bdat_valid = 0; vq_full = 0; fill_ready = 0;
  endtask

  task automatic set_lookup(input bit st, input int line, input logic [LB-1:0] be, input logic [7:0] fillb);
    lk_valid = 1; lk_store = st; lk_line = LAW'(line); lk_be = be; lk_data = {LB{fillb}};
  endtask

  task automatic set_beat(input int idx, input logic [7:0] v);
    bdat_valid = 1; bdat_idx = 2'(idx); bdat_data = {BB{v}};
  endtask

  task automatic random_inputs();
    int pick;
    idle_inputs();
    lk_valid = ($urandom % 3) != 0;
    lk_store = $urandom % 2;
    lk_line = LAW'($urandom % 6);
    lk_be = LB'($urandom);
    lk_data = {$urandom, $urandom, $urandom, $urandom};
    breq_ready = ($urandom % 4) != 0;
    vq_full = ($urandom % 8) == 0;
    fill_ready = ($urandom % 4) != 0;
    pick = -1;
    for (int i = 0; i < NE; i++)
      if (pick < 0 && mv[i] && mreq[i] && mcnt[i] < NBEAT) pick = i;
    if (pick >= 0 && ($urandom % 3) != 0) begin
      bdat_valid = 1; bdat_idx = 2'(pick); bdat_data = $urandom;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      mv[i] = 0; mreq[i] = 0; mcnt[i] = 0; mline[i] = '0;
      for (int b = 0; b < LB; b++) begin mmask[i][b] = 0; mdat[i][b] = '0; end
    end
    m_rsp_v = 0; m_rsp_ok = 0; m_rsp_mg = 0; m_wake_v = 0; m_nf = 0;
    m_rsp_idx = 0; m_wake_idx = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    chk("R11 full", full, 0);
    chk("R11 breq_valid", breq_valid, 0);
    chk("R11 fill_valid", fill_valid, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 wake_valid", wake_valid, 0);
    chk("R11 notfull_evt", notfull_evt, 0);

    // Directed: allocation, merge, store/beat collision, victim hold, full, release reuse
    cycle_begin(); idle_inputs(); set_lookup(1, 10, 16'h0003, 8'hAA); model_step();
    cycle_begin(); idle_inputs(); set_lookup(0, 20, '0, 8'h00); model_step();
    after_edge();
    chk("R2 new entry idx", rsp_idx, 1);
    chk("R2 new entry not merged", rsp_merged, 0);
    cycle_begin(); idle_inputs(); set_lookup(0, 10, '0, 8'h00); model_step();
    after_edge();
    chk("R2 merge idx", rsp_idx, 0);
    chk("R2 merge flag", rsp_merged, 1);
    cycle_begin(); idle_inputs(); breq_ready = 1; model_step();
    cycle_begin(); idle_inputs(); breq_ready = 1; model_step();
    cycle_begin(); idle_inputs(); set_beat(0, 8'h11); set_lookup(1, 10, 16'h0006, 8'h55); model_step();
    cycle_begin(); idle_inputs(); set_beat(0, 8'h22); vq_full = 1; fill_ready = 1; model_step();
    cycle_begin(); idle_inputs(); set_beat(0, 8'h33); vq_full = 1; fill_ready = 1; model_step();
    cycle_begin(); idle_inputs(); set_beat(0, 8'h44); vq_full = 1; fill_ready = 1; model_step();
    cycle_begin(); idle_inputs(); vq_full = 1; fill_ready = 1; model_step();
    after_edge();
    chk("R9 fill held by victim full", fill_valid, 0);
    cycle_begin(); idle_inputs(); model_step();
    after_edge();
    chk("R9 fill raised", fill_valid, 1);
    chk("R7 store beats same-cycle beat", fill_data[31:0], 32'h115555AA);
    chk("R6 second beat bytes", fill_data[63:32], 32'h22222222);
    cycle_begin(); idle_inputs(); set_lookup(0, 30, '0, 8'h00); model_step();
    cycle_begin(); idle_inputs(); set_lookup(0, 40, '0, 8'h00); model_step();
    cycle_begin(); idle_inputs(); set_lookup(0, 50, '0, 8'h00); model_step();
    after_edge();
    chk("R3 full when all held", full, 1);
    chk("R3 rejected when full", rsp_ok, 0);
    cycle_begin(); idle_inputs(); set_lookup(0, 10, '0, 8'h00); fill_ready = 1; model_step();
    after_edge();
    chk("R4 accepted on release", rsp_ok, 1);
    chk("R4 takes released entry", rsp_idx, 0);
    chk("R4 not merged into leaving entry", rsp_merged, 0);
    chk("R10 wake idx", wake_idx, 0);
    chk("R10 notfull pulse", notfull_evt, 1);

    // Constrained random traffic, compared every clock
    for (int c = 0; c < 4000; c++) begin
      cycle_begin();
      random_inputs();
      model_step();
    end
    cycle_begin();
    idle_inputs();
    model_step();
    cycle_begin();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule